// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit integers over several clock cycles. It produces a 64-bit product, handed out as an upper word and a lower word. It needs only one 32-bit adder. The multiplier operand sits in the low half of a single double-width product register. The multiplicand is added into the high half. The whole register shifts right by one bit on every iteration, and one iteration takes one clock cycle.

A single-cycle start pulse loads the operands together with a signed/unsigned selection. The block stays busy for one iteration per operand bit. After the last iteration it raises a one-cycle done pulse. The product and an overflow flag then stay on the outputs until the next accepted start. The overflow flag shows that the product does not fit in one word.

In signed mode the block takes the magnitudes of both operands and multiplies them unsigned. It negates the double-width result when the operand signs differ. The carry out of each add is shifted into the top bit of the register, so no product bit is lost.

Top module: `shmul_top`

## Requirements
- R1: After reset, busy_o, done_o, ovf_o, hi_o and lo_o are all 0.
- R2: A start_i that is high at a clock edge while busy_o is low is accepted. busy_o is high after that edge. done_o is high for exactly one cycle, following the 32nd edge after the accepted start edge, and busy_o is low in that same cycle.
- R3: With signed_i = 0 at the accepted start, {hi_o, lo_o} equals the unsigned 64-bit product of a_i and b_i.
- R4: With signed_i = 1 at the accepted start, {hi_o, lo_o} equals the two's-complement 64-bit product of a_i and b_i, both read as signed values.
- R5: In unsigned mode, ovf_o is 1 exactly when hi_o is nonzero.
- R6: In signed mode, ovf_o is 1 exactly when hi_o is not 32 copies of lo_o bit 31.
- R7: A start_i pulse while busy_o is high has no effect. The running product, its mode and its done timing are unchanged.
- R8: Changes to a_i, b_i and signed_i after the accepted start edge have no effect. hi_o, lo_o and ovf_o stay constant from done until the next accepted start.
- R9: Products that need carries through the top bit are exact. Examples are 0xFFFFFFFF squared unsigned, and -2^31 times -2^31 signed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| signed_i | input | 1 | 1 = signed, 0 = unsigned, sampled at start |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Upper word of the product |
| lo_o | output | 32 | Lower word of the product |
| ovf_o | output | 1 | Product does not fit in one word for the sampled mode |

## Verification
The bench builds the block with its default 32-bit operand width. At that width the exact latency of 32 iterations is checked edge by edge. At that width the most negative operand can also be driven in signed mode, where its magnitude needs every bit of the adder. The all-ones unsigned square forces a carry out of the adder on most iterations, so losing any carry would show in hi_o. Operands and mode are changed while the block is busy, and extra start pulses are sent then too. This shows that only values sampled at the accepted edge reach the result.

// File: rtl/shmul_pkg.sv
package shmul_pkg;
  typedef enum logic {
    MODE_UNS = 1'b0,
    MODE_SGN = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/shmul_prep.sv
// Turns operands into magnitudes and a result-sign flag.
module shmul_prep
  import shmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  mul_mode_e    mode_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_o
);
  logic a_neg, b_neg;

  assign a_neg   = (mode_i == MODE_SGN) && a_i[W-1];
  assign b_neg   = (mode_i == MODE_SGN) && b_i[W-1];
  // most negative value maps to itself, which is the correct unsigned magnitude
  assign mag_a_o = a_neg ? (~a_i + 1'b1) : a_i;
  assign mag_b_o = b_neg ? (~b_i + 1'b1) : b_i;
  assign neg_o   = a_neg ^ b_neg;
endmodule

// File: rtl/shmul_core.sv
// Iterates one conditional add plus right shift per cycle.
module shmul_core #(
  parameter int W  = 32,
  localparam int PW = 2 * W,
  localparam int CW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  output logic [PW-1:0] prod_o,
  output logic          busy_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LastCnt = CW'(W - 1);

  logic [PW-1:0] prod_q;
  logic [W-1:0]  mcand_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W:0]    sum;

  // carry out of the add lands in the top bit after the shift
  assign sum = {1'b0, prod_q[PW-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      mcand_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load_i) begin
      prod_q  <= {{W{1'b0}}, mplier_i};
      mcand_q <= mcand_i;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      prod_q <= {sum, prod_q[W-1:1]};
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == LastCnt) busy_q <= 1'b0;
    end
  end

  assign prod_o = prod_q;
  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == LastCnt);

  // R7
  mcand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !load_i) |=> $stable(mcand_q));
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o && !load_i) |=> (busy_q && cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/shmul_finish.sv
// Applies the result sign and derives the overflow flag.
module shmul_finish
  import shmul_pkg::*;
#(
  parameter int W  = 32,
  localparam int PW = 2 * W
) (
  input  logic [PW-1:0] prod_i,
  input  logic          neg_i,
  input  mul_mode_e     mode_i,
  output logic [W-1:0]  hi_o,
  output logic [W-1:0]  lo_o,
  output logic          ovf_o
);
  logic [PW-1:0] res;

  assign res  = neg_i ? (~prod_i + 1'b1) : prod_i;
  assign hi_o = res[PW-1:W];
  assign lo_o = res[W-1:0];

  always_comb begin
    if (mode_i == MODE_SGN) ovf_o = (hi_o != {W{lo_o[W-1]}});
    else                    ovf_o = (hi_o != '0);
  end
endmodule

// File: rtl/shmul_top.sv
module shmul_top
  import shmul_pkg::*;
#(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         ovf_o
);
  mul_mode_e     mode_in, mode_q;
  logic [W-1:0]  mag_a, mag_b;
  logic          neg_in, neg_q;
  logic          load, busy, last;
  logic          done_q;
  logic [PW-1:0] prod;

  assign mode_in = signed_i ? MODE_SGN : MODE_UNS;
  assign load    = start_i && !busy;

  shmul_prep #(.W(W)) u_prep (
    .a_i     (a_i),
    .b_i     (b_i),
    .mode_i  (mode_in),
    .mag_a_o (mag_a),
    .mag_b_o (mag_b),
    .neg_o   (neg_in)
  );

  shmul_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .mcand_i  (mag_a),
    .mplier_i (mag_b),
    .prod_o   (prod),
    .busy_o   (busy),
    .last_o   (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_UNS;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last && !load;
      if (load) begin
        mode_q <= mode_in;
        neg_q  <= neg_in;
      end
    end
  end

  shmul_finish #(.W(W)) u_finish (
    .prod_i (prod),
    .neg_i  (neg_q),
    .mode_i (mode_q),
    .hi_o   (hi_o),
    .lo_o   (lo_o),
    .ovf_o  (ovf_o)
  );

  assign busy_o = busy;
  assign done_o = done_q;

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mode_q));
  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o) && $stable(ovf_o)));
endmodule

// File: tb/tb_shmul_top.sv
`timescale 1ns/1ps
module tb_shmul_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         busy_o, done_o, ovf_o;
  logic [W-1:0] hi_o, lo_o;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  shmul_top #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .signed_i(signed_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .hi_o(hi_o), .lo_o(lo_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic signed [63:0] sa, sb;
    if (s) begin
      sa = $signed({{32{a[31]}}, a});
      sb = $signed({{32{b[31]}}, b});
      return sa * sb;
    end
    return {32'h0, a} * {32'h0, b};
  endfunction

  function automatic logic ref_ovf(input logic [63:0] p, input logic s);
    if (s) return p[63:32] != {32{p[31]}};
    return p[63:32] != 32'h0;
  endfunction

  // Accept a start, optionally disturb inputs while busy, then check timing and result.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic disturb, input string req);
    logic [63:0] exp;
    exp = ref_prod(a, b, s);
    @(negedge clk);
    a_i = a; b_i = b; signed_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", {63'h0, busy_o}, 64'h1);
    for (int k = 1; k < 32; k++) begin
      if (disturb && k == 5) begin
        a_i = ~a; b_i = b ^ 32'h5a5a_0001; signed_i = ~s; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      if (done_o !== 1'b0) check("R2 early done", {63'h0, done_o}, 64'h0);
    end
    if (disturb) begin a_i = 32'h1234_5678; b_i = 32'h9abc_def0; signed_i = ~signed_i; end
    @(negedge clk);
    check("R2 done at 32", {62'h0, done_o, busy_o}, 64'h2);
    check({req, " product"}, {hi_o, lo_o}, exp);
    check(s ? "R6 overflow" : "R5 overflow", {63'h0, ovf_o}, {63'h0, ref_ovf(exp, s)});
    @(negedge clk);
    check("R2 done one cycle", {63'h0, done_o}, 64'h0);
    check({req, " product after done"}, {hi_o, lo_o}, exp);
  endtask

  task automatic test_reset();
    check("R1 reset flags", {61'h0, busy_o, done_o, ovf_o}, 64'h0);
    check("R1 reset result", {hi_o, lo_o}, 64'h0);
  endtask

  task automatic test_unsigned();
    run_op(32'd2, 32'd3, 1'b0, 1'b0, "R3");
    run_op(32'h0001_0000, 32'h0001_0000, 1'b0, 1'b0, "R3");
    run_op(32'hdead_beef, 32'h0000_0000, 1'b0, 1'b0, "R3");
    run_op(32'h8000_0001, 32'h0000_0007, 1'b0, 1'b0, "R3");
    run_op(32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0, "R9");
  endtask

  task automatic test_signed();
    run_op(32'hffff_fffe, 32'd3, 1'b1, 1'b0, "R4");
    run_op(32'hffff_fff9, 32'hffff_fffd, 1'b1, 1'b0, "R4");
    run_op(32'h8000_0000, 32'd1, 1'b1, 1'b0, "R4");
    run_op(32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0, "R4");
    run_op(32'h7fff_ffff, 32'h7fff_ffff, 1'b1, 1'b0, "R4");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R9");
    run_op(32'h0001_0000, 32'hffff_0000, 1'b1, 1'b0, "R6");
  endtask

  task automatic test_ignore_busy();
    run_op(32'hfedc_ba98, 32'h0000_1234, 1'b1, 1'b1, "R7");
    run_op(32'h0000_0003, 32'hffff_fffb, 1'b0, 1'b1, "R7");
  endtask

  task automatic test_hold();
    logic [63:0] held;
    logic        hov;
    run_op(32'h0000_1111, 32'h0002_0000, 1'b0, 1'b0, "R8");
    held = {hi_o, lo_o};
    hov  = ovf_o;
    a_i = 32'hffff_ffff; b_i = 32'h8000_0000; signed_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 hold product", {hi_o, lo_o}, held);
    check("R8 hold overflow", {63'h0, ovf_o}, {63'h0, hov});
    check("R8 idle", {62'h0, busy_o, done_o}, 64'h0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset();
    test_unsigned();
    test_signed();
    test_ignore_busy();
    test_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule